// File: doc/BRIEF.md
# Host bridge control register bank

This block is the register bank of a bus host bridge, reached by full 32-bit reads and writes on a simple valid/ready register port with a 10-bit byte offset. It holds a 64-word local configuration header and three bridge registers: a configuration address pointer, a memory base and an I/O base. Offsets that do not decode to one of these read as zero, and writes to them are dropped.

An indirect data port lets software reach configuration space behind the bridge. A write to the port sends a configuration write downstream at the address in the pointer register. A read of the port sends a configuration read downstream and stalls the register port until the data returns. The block also drives the current I/O window base. It decodes whether a probe address falls in the 256 KB I/O window, and it raises a one-cycle remap pulse when the window moves.

Top module: `hb_regbank`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC (word aligned) address 64 header words that are fully readable and writable. Word n is at offset 4*n, and byte 4*n+k of the header is bits 8k+7:8k of word n.
- R2: After reset, header word 0 reads {DEVICE_ID, VENDOR_ID} with the vendor in bits 15:0. Word 1 reads 0x02900080 (bytes 0x04..0x07 = 0x80, 0x00, 0x90, 0x02). All other header words, the pointer and the memory base read 0. The I/O base reads 0xFE240000 and io_remap is low.
- R3: Offset 0x1C0 is the configuration pointer. All 32 bits are written and read back unmasked.
- R4: Offset 0x1C4 is the memory base. A write stores the value ANDed with 0xFF000001, so bits 23:1 always read zero.
- R5: Offset 0x1C8 is the I/O base. A write whose bits 31:18 differ from the stored bits 31:18 stores the value ANDed with 0xFFFC0001. A write with equal bits 31:18 changes nothing, bit 0 included.
- R6: io_remap is high for exactly the one cycle after the clock edge that accepts a changing I/O base write. io_base already shows the new value in that cycle.
- R7: io_win_hit is high exactly when probe_addr[31:18] equals io_base[31:18].
- R8: A write to offset 0x220 issues one downstream write, with cfg_req_write = 1, cfg_req_addr equal to the pointer and cfg_req_wdata equal to the written data. req_ready stays low until the downstream side has accepted the request.
- R9: A read of offset 0x220 issues one downstream read (cfg_req_write = 0) at the pointer address. req_ready stays low until cfg_rsp_valid has returned, and req_rdata then carries cfg_rsp_data.
- R10: Reads of misaligned offsets, of 0x100..0x1BC, of 0x1CC..0x21C and of 0x224 and above return 0. Writes to them change no register and cause no downstream request.
- R11: While cfg_req_valid is high and cfg_req_ready is low, the request stays valid with unchanged address, data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access completes on a clock edge with req_valid high |
| req_rdata | output | 32 | Read data, valid while req_ready is high |
| cfg_req_valid | output | 1 | Downstream configuration request |
| cfg_req_write | output | 1 | Downstream direction, 1 = write |
| cfg_req_addr | output | 32 | Downstream configuration address |
| cfg_req_wdata | output | 32 | Downstream write data |
| cfg_req_ready | input | 1 | Downstream accepts the request |
| cfg_rsp_valid | input | 1 | Downstream read data valid |
| cfg_rsp_data | input | 32 | Downstream read data |
| probe_addr | input | 32 | Address tested against the I/O window |
| io_base | output | 32 | Current I/O base register |
| io_win_hit | output | 1 | probe_addr lies in the 256 KB I/O window |
| io_remap | output | 1 | One-cycle pulse when the window moves |

## Verification
The remap pulse and the window-hit decode can change in the same cycle. This happens when an I/O base write moves the window onto an address that is already held on probe_addr. The bench holds the probe at the future base and checks that io_win_hit is low before the write. It then checks that io_remap and io_win_hit are both high in the cycle after acceptance, with io_base already at the new value. A second write with the same upper bits must leave both the pulse and the stored value untouched.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned REG_ADDR_W = 10;
    localparam int unsigned HDR_WORDS  = 64;
    localparam int unsigned HDR_IDX_W  = $clog2(HDR_WORDS);
    localparam int unsigned WIN_LSB    = 18;

    localparam logic [REG_ADDR_W-1:0] HDR_LIMIT = REG_ADDR_W'(HDR_WORDS * 4);
    localparam logic [REG_ADDR_W-1:0] OFF_PTR   = 10'h1C0;
    localparam logic [REG_ADDR_W-1:0] OFF_MEMB  = 10'h1C4;
    localparam logic [REG_ADDR_W-1:0] OFF_IOB   = 10'h1C8;
    localparam logic [REG_ADDR_W-1:0] OFF_PORT  = 10'h220;

    localparam logic [WORD_W-1:0] MEMB_MASK = 32'hFF00_0001;
    localparam logic [WORD_W-1:0] IOB_MASK  = 32'hFFFC_0001;
    localparam logic [WORD_W-1:0] IOB_RESET = 32'hFE24_0000;
    localparam logic [WORD_W-1:0] HDR_CMD_RESET = 32'h0290_0080;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HDR,
        SEL_PTR,
        SEL_MEMB,
        SEL_IOB,
        SEL_PORT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e             sel;
        logic [HDR_IDX_W-1:0] idx;
    } decode_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_REQ,
        PS_WAIT,
        PS_DONE
    } port_state_e;

    typedef struct packed {
        logic              write;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } cfg_req_t;

    function automatic decode_t decode_offset(input logic [REG_ADDR_W-1:0] a);
        decode_t d;
        d.sel = SEL_NONE;
        d.idx = a[HDR_IDX_W+1:2];
        if (a[1:0] == 2'b00) begin
            if (a < HDR_LIMIT)      d.sel = SEL_HDR;
            else if (a == OFF_PTR)  d.sel = SEL_PTR;
            else if (a == OFF_MEMB) d.sel = SEL_MEMB;
            else if (a == OFF_IOB)  d.sel = SEL_IOB;
            else if (a == OFF_PORT) d.sel = SEL_PORT;
        end
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] hdr_reset_word(input int idx,
                                                         input logic [15:0] ven,
                                                         input logic [15:0] dev);
        if (idx == 0) return {dev, ven};
        if (idx == 1) return HDR_CMD_RESET;
        return '0;
    endfunction

endpackage

// File: rtl/hbr_cfg_hdr.sv
module hbr_cfg_hdr
    import hbr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID = 16'h7C31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [HDR_IDX_W-1:0] idx,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data
);

    logic [WORD_W-1:0] words [HDR_WORDS];

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] RST_VAL = hdr_reset_word(g, VENDOR_ID, DEVICE_ID);
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= RST_VAL;
            else if (wr_en && idx == HDR_IDX_W'(g))
                words[g] <= wr_data;
        end
    end

    assign rd_data = words[idx];

endmodule

// File: rtl/hbr_iowin.sv
module hbr_iowin
    import hbr_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_BASE = IOB_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] probe_addr,
    output logic [WORD_W-1:0] base,
    output logic              win_hit,
    output logic              remap
);

    localparam logic [WORD_W-1:0] HI_MASK = {{(WORD_W-WIN_LSB){1'b1}}, {WIN_LSB{1'b0}}};

    logic [WORD_W-1:0] base_q;
    logic              remap_q;
    logic              moves;

    assign moves = wr_en && (((wr_data ^ base_q) & HI_MASK) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= RESET_BASE;
            remap_q <= 1'b0;
        end else begin
            remap_q <= moves;
            if (moves)
                base_q <= wr_data & IOB_MASK;
        end
    end

    assign base    = base_q;
    assign remap   = remap_q;
    assign win_hit = ((probe_addr ^ base_q) & HI_MASK) == '0;

    // R6: any change of the stored base is announced by the pulse
    a_r6_change_pulses: assert property (@(posedge clk) disable iff (rst)
        (base_q != $past(base_q)) |-> remap_q);

    // R5: a pulse only follows a real move of the upper base bits
    a_r5_pulse_moves_base: assert property (@(posedge clk) disable iff (rst)
        remap_q |-> (base_q[WORD_W-1:WIN_LSB] != $past(base_q[WORD_W-1:WIN_LSB])));

endmodule

// File: rtl/hbr_cfg_port.sv
module hbr_cfg_port
    import hbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cfg_req_t          req_in,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              cfg_req_valid,
    output cfg_req_t          cfg_req,
    input  logic              cfg_req_ready,
    input  logic              cfg_rsp_valid,
    input  logic [WORD_W-1:0] cfg_rsp_data
);

    port_state_e state_q, state_d;
    cfg_req_t    req_q;
    logic [WORD_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (start) state_d = PS_REQ;
            PS_REQ:  if (cfg_req_ready) state_d = req_q.write ? PS_DONE : PS_WAIT;
            PS_WAIT: if (cfg_rsp_valid) state_d = PS_DONE;
            PS_DONE: state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_IDLE && start)
                req_q <= req_in;
            if (state_q == PS_WAIT && cfg_rsp_valid)
                rdata_q <= cfg_rsp_data;
        end
    end

    assign cfg_req_valid = (state_q == PS_REQ);
    assign cfg_req       = req_q;
    assign done          = (state_q == PS_DONE);
    assign rdata         = rdata_q;

    // R11: an unaccepted request is held unchanged
    a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
        (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid && $stable(cfg_req)));

    // R9: completion is reported for one cycle only
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/hb_regbank.sv
module hb_regbank
    import hbr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID = 16'h7C31
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic [WORD_W-1:0]     req_rdata,
    output logic                  cfg_req_valid,
    output logic                  cfg_req_write,
    output logic [WORD_W-1:0]     cfg_req_addr,
    output logic [WORD_W-1:0]     cfg_req_wdata,
    input  logic                  cfg_req_ready,
    input  logic                  cfg_rsp_valid,
    input  logic [WORD_W-1:0]     cfg_rsp_data,
    input  logic [WORD_W-1:0]     probe_addr,
    output logic [WORD_W-1:0]     io_base,
    output logic                  io_win_hit,
    output logic                  io_remap
);

    decode_t           dec;
    logic              accept;
    logic              wr_acc;
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] memb_q;
    logic [WORD_W-1:0] hdr_rdata;
    logic              port_done;
    logic [WORD_W-1:0] port_rdata;
    cfg_req_t          port_req_in;
    cfg_req_t          port_req_out;

    assign dec       = decode_offset(req_addr);
    assign req_ready = (dec.sel == SEL_PORT) ? port_done : 1'b1;
    assign accept    = req_valid && req_ready;
    assign wr_acc    = accept && req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            memb_q <= '0;
        end else begin
            if (wr_acc && dec.sel == SEL_PTR)  ptr_q  <= req_wdata;
            if (wr_acc && dec.sel == SEL_MEMB) memb_q <= req_wdata & MEMB_MASK;
        end
    end

    hbr_cfg_hdr #(
        .VENDOR_ID(VENDOR_ID),
        .DEVICE_ID(DEVICE_ID)
    ) u_hdr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_acc && dec.sel == SEL_HDR),
        .idx     (dec.idx),
        .wr_data (req_wdata),
        .rd_data (hdr_rdata)
    );

    hbr_iowin #(
        .RESET_BASE(IOB_RESET)
    ) u_iowin (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_acc && dec.sel == SEL_IOB),
        .wr_data    (req_wdata),
        .probe_addr (probe_addr),
        .base       (io_base),
        .win_hit    (io_win_hit),
        .remap      (io_remap)
    );

    assign port_req_in = '{write: req_write, addr: ptr_q, data: req_wdata};

    hbr_cfg_port u_port (
        .clk           (clk),
        .rst           (rst),
        .start         (req_valid && dec.sel == SEL_PORT),
        .req_in        (port_req_in),
        .done          (port_done),
        .rdata         (port_rdata),
        .cfg_req_valid (cfg_req_valid),
        .cfg_req       (port_req_out),
        .cfg_req_ready (cfg_req_ready),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_data  (cfg_rsp_data)
    );

    assign cfg_req_write = port_req_out.write;
    assign cfg_req_addr  = port_req_out.addr;
    assign cfg_req_wdata = port_req_out.data;

    always_comb begin
        unique case (dec.sel)
            SEL_HDR:  req_rdata = hdr_rdata;
            SEL_PTR:  req_rdata = ptr_q;
            SEL_MEMB: req_rdata = memb_q;
            SEL_IOB:  req_rdata = io_base;
            SEL_PORT: req_rdata = port_rdata;
            default:  req_rdata = '0;
        endcase
    end

    // R8: downstream requests always target the pointer address
    a_r8_addr_from_ptr: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |-> (cfg_req_addr == ptr_q));

    // R10: completed reads of unmapped offsets return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && dec.sel == SEL_NONE) |-> (req_rdata == '0));

    // R4: stored memory base never holds bits outside its mask
    a_r4_memb_clean: assert property (@(posedge clk) disable iff (rst)
        (memb_q[23:1] == '0));

endmodule

// File: tb/test_hb_regbank.sv
module test_hb_regbank;

    localparam logic [15:0] VEN = 16'h1AB5;
    localparam logic [15:0] DEV = 16'h7C31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] req_rdata;
    logic        cfg_req_valid;
    logic        cfg_req_write;
    logic [31:0] cfg_req_addr;
    logic [31:0] cfg_req_wdata;
    logic        cfg_req_ready = 1'b0;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_data = '0;
    logic [31:0] probe_addr = '0;
    logic [31:0] io_base;
    logic        io_win_hit;
    logic        io_remap;

    int checks = 0;
    int errors = 0;

    // downstream target model
    logic [31:0] tgt_mem [16];
    int          lat = 1;
    int          n_wr = 0;
    int          n_rd = 0;
    int          hold_err = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] last_data = '0;

    always #5 clk = ~clk;

    hb_regbank #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) i_hb_regbank (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
        .cfg_req_addr(cfg_req_addr), .cfg_req_wdata(cfg_req_wdata),
        .cfg_req_ready(cfg_req_ready), .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rsp_data(cfg_rsp_data), .probe_addr(probe_addr),
        .io_base(io_base), .io_win_hit(io_win_hit), .io_remap(io_remap)
    );

    initial begin
        for (int i = 0; i < 16; i++) tgt_mem[i] = 32'hA5A5_0000 + 32'(i);
        forever begin
            @(negedge clk);
            if (cfg_req_valid) begin
                logic [31:0] a0;
                logic [31:0] d0;
                logic        w0;
                a0 = cfg_req_addr; d0 = cfg_req_wdata; w0 = cfg_req_write;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!cfg_req_valid || cfg_req_addr !== a0 ||
                        cfg_req_wdata !== d0 || cfg_req_write !== w0)
                        hold_err++;
                end
                cfg_req_ready = 1'b1;
                last_addr = a0; last_data = d0;
                if (w0) begin
                    n_wr++;
                    tgt_mem[a0[5:2]] = d0;
                end else begin
                    n_rd++;
                end
                @(negedge clk);
                cfg_req_ready = 1'b0;
                if (!w0) begin
                    for (int k = 0; k < lat; k++) @(negedge clk);
                    cfg_rsp_valid = 1'b1;
                    cfg_rsp_data  = tgt_mem[a0[5:2]];
                    @(negedge clk);
                    cfg_rsp_valid = 1'b0;
                    cfg_rsp_data  = '0;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic wr, input logic [9:0] a, input logic [31:0] d,
                            output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        q = req_rdata;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr32(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_xfer(1'b1, a, d, q);
    endtask

    task automatic rd32(input logic [9:0] a, output logic [31:0] q);
        bus_xfer(1'b0, a, '0, q);
    endtask

    task automatic t_reset();
        logic [31:0] q;
        check("R2 remap low", 32'(io_remap), 32'd0);
        rd32(10'h000, q); check("R2 id word", q, {DEV, VEN});
        rd32(10'h004, q); check("R2 word1", q, 32'h0290_0080);
        rd32(10'h008, q); check("R2 word2", q, 32'h0);
        rd32(10'h0FC, q); check("R2 word63", q, 32'h0);
        rd32(10'h1C0, q); check("R2 pointer", q, 32'h0);
        rd32(10'h1C4, q); check("R2 membase", q, 32'h0);
        rd32(10'h1C8, q); check("R2 iobase", q, 32'hFE24_0000);
    endtask

    task automatic t_header();
        logic [31:0] q;
        wr32(10'h000, 32'h1234_5678);
        wr32(10'h0FC, 32'hFFFF_0000);
        wr32(10'h080, 32'h0F0F_F0F0);
        rd32(10'h000, q); check("R1 word0", q, 32'h1234_5678);
        rd32(10'h0FC, q); check("R1 word63", q, 32'hFFFF_0000);
        rd32(10'h080, q); check("R1 word32", q, 32'h0F0F_F0F0);
        rd32(10'h004, q); check("R1 neighbour kept", q, 32'h0290_0080);
    endtask

    task automatic t_pointer();
        logic [31:0] q;
        wr32(10'h1C0, 32'hDEAD_BEEF);
        rd32(10'h1C0, q); check("R3 pointer", q, 32'hDEAD_BEEF);
    endtask

    task automatic t_membase();
        logic [31:0] q;
        wr32(10'h1C4, 32'hFFFF_FFFF);
        rd32(10'h1C4, q); check("R4 mask ones", q, 32'hFF00_0001);
        wr32(10'h1C4, 32'h1234_5678);
        rd32(10'h1C4, q); check("R4 mask pattern", q, 32'h1200_0000);
    endtask

    task automatic t_iowin();
        logic [31:0] q;
        probe_addr = 32'hFE25_0000; #1;
        check("R7 hit at reset base", 32'(io_win_hit), 32'd1);
        wr32(10'h1C8, 32'h4000_0003);
        check("R6 pulse after move", 32'(io_remap), 32'd1);
        check("R5 base moved", io_base, 32'h4000_0001);
        check("R7 old window miss", 32'(io_win_hit), 32'd0);
        @(negedge clk);
        check("R6 pulse one cycle", 32'(io_remap), 32'd0);
        wr32(10'h1C8, 32'h4003_FFFE);
        check("R6 no pulse same bits", 32'(io_remap), 32'd0);
        rd32(10'h1C8, q); check("R5 same bits ignored", q, 32'h4000_0001);
        probe_addr = 32'h4003_FFFC; #1;
        check("R7 top of window", 32'(io_win_hit), 32'd1);
        probe_addr = 32'h4004_0000; #1;
        check("R7 past window", 32'(io_win_hit), 32'd0);
        // move onto the held probe: pulse and hit in the same cycle
        probe_addr = 32'h8000_0000; #1;
        check("R7 miss before move", 32'(io_win_hit), 32'd0);
        wr32(10'h1C8, 32'h8000_0000);
        check("R6 pulse with hit", 32'(io_remap), 32'd1);
        check("R7 hit with pulse", 32'(io_win_hit), 32'd1);
    endtask

    task automatic t_port_write();
        int w0;
        w0 = n_wr;
        lat = 3;
        wr32(10'h1C0, 32'h8000_0010);
        wr32(10'h220, 32'hCAFE_F00D);
        check("R8 one write", 32'(n_wr - w0), 32'd1);
        check("R8 address", last_addr, 32'h8000_0010);
        check("R8 data", last_data, 32'hCAFE_F00D);
        check("R11 held while waiting", 32'(hold_err), 32'd0);
        check("R8 target stored", tgt_mem[4], 32'hCAFE_F00D);
    endtask

    task automatic t_port_read();
        logic [31:0] q;
        int r0;
        r0 = n_rd;
        lat = 2;
        wr32(10'h1C0, 32'h8000_0018);
        rd32(10'h220, q);
        check("R9 read data", q, 32'hA5A5_0006);
        check("R9 address", last_addr, 32'h8000_0018);
        lat = 0;
        rd32(10'h220, q);
        check("R9 zero latency", q, 32'hA5A5_0006);
        check("R9 two reads", 32'(n_rd - r0), 32'd2);
        check("R11 held on reads", 32'(hold_err), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] q;
        int c0;
        c0 = n_wr + n_rd;
        wr32(10'h002, 32'hFFFF_FFFF);
        wr32(10'h1CC, 32'hFFFF_FFFF);
        wr32(10'h1D0, 32'hFFFF_FFFF);
        wr32(10'h224, 32'hFFFF_FFFF);
        wr32(10'h222, 32'hFFFF_FFFF);
        rd32(10'h002, q); check("R10 misaligned read", q, 32'h0);
        rd32(10'h1CC, q); check("R10 gap read", q, 32'h0);
        rd32(10'h100, q); check("R10 above header", q, 32'h0);
        rd32(10'h224, q); check("R10 past window", q, 32'h0);
        rd32(10'h3FC, q); check("R10 top offset", q, 32'h0);
        rd32(10'h000, q); check("R10 word0 untouched", q, 32'h1234_5678);
        rd32(10'h1C0, q); check("R10 pointer untouched", q, 32'h8000_0018);
        rd32(10'h1C4, q); check("R10 membase untouched", q, 32'h1200_0000);
        rd32(10'h1C8, q); check("R10 iobase untouched", q, 32'h8000_0000);
        check("R10 no downstream", 32'(n_wr + n_rd - c0), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_header();
        t_pointer();
        t_membase();
        t_iowin();
        t_port_write();
        t_port_read();
        t_unmapped();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule